// File: doc/BRIEF.md
# Sweep Gate and Holdoff Controller

This block decides when the timebase of an analog oscilloscope is allowed to run a sweep. It accepts trigger pulses from the trigger comparator, an end-of-sweep indication from the ramp generator, a two-bit operating mode, a single-sweep rearm pulse and a pulse that marks a reload of the instrument settings. From these it drives the sweep gate that starts and holds the ramp, a holdoff pulse that keeps the timebase quiet after each sweep, a trigger-presence indication, and a free-run request used in auto mode.

Each sweep ends the same way. End-of-sweep, or a settings reload, starts a holdoff interval of fixed length. Holdoff clears the gate and blocks new starts. The same holdoff pulse is exported as a clock enable for the downstream horizontal and vertical logic. A retriggerable timer shows whether triggers are still arriving. In auto mode, an idle counter makes the sweep free-run when triggers stop. Single-sweep mode allows one sweep per rearm. X-Y mode keeps the gate closed. All timer lengths are parameters counted in system clock cycles.

Top module: `sweep_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `sweep_gate`, `holdoff`, `trig_present` and `auto_start` are 0 and `trig_det_n` is 1. Single-sweep mode starts disarmed.
- R2: A cycle with `trig_pulse` high and `sweep_dis_n` high makes `sweep_gate` read 1 on the next cycle.
- R3: While `sweep_dis_n` is low, `trig_pulse` neither opens the gate nor reloads the trigger-presence timer.
- R4: When `eos` is high in a cycle where `sweep_gate` is 1 and `holdoff` is 0, `holdoff` is 1 for exactly HOLD_CYC cycles, starting on the next cycle. The gate reads 0 from the cycle after `holdoff` rises.
- R5: `sweep_dis_n` is 0 while `holdoff` is 1, while mode is X-Y, and while mode is single and the block is disarmed. Otherwise it is 1. Mode codes: 2'b00 normal, 2'b01 auto, 2'b10 single, 2'b11 X-Y.
- R6: After the last accepted trigger, `trig_present` is 1 for exactly PRES_CYC cycles. `trig_det_n` is always its inverse.
- R7: In auto mode (2'b01), `auto_start` rises once AUTO_CYC cycles have passed without a trigger pulse, counted from the end of holdoff, provided the gate is closed and sweeps are enabled. The gate opens on the next cycle.
- R8: In single mode (2'b10), `ss_reset` arms the block and the next sweep start disarms it. Exactly one sweep runs per rearm, and after its holdoff `sweep_dis_n` stays 0 until the next `ss_reset`.
- R9: In X-Y mode (2'b11), `sweep_gate` reads 0 from the next cycle on, and trigger pulses have no effect.
- R10: A `chain_load` pulse makes `holdoff` read 1 on the next cycle in any state. This ends any running sweep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_pulse | input | 1 | One-cycle trigger event from the comparator |
| eos | input | 1 | End of sweep from the ramp generator, active high |
| mode | input | 2 | 00 normal, 01 auto, 10 single, 11 X-Y |
| ss_reset | input | 1 | Arms one sweep in single mode |
| chain_load | input | 1 | Settings reload; forces a holdoff |
| sweep_gate | output | 1 | Runs the ramp while high |
| holdoff | output | 1 | Holdoff interval; also a clock enable for the downstream logic |
| trig_present | output | 1 | Triggers seen within the last PRES_CYC cycles |
| trig_det_n | output | 1 | Inverse of trig_present |
| auto_start | output | 1 | Free-run start request in auto mode |
| sweep_dis_n | output | 1 | Low while sweep starts are blocked |

## Verification
The main function is exercised with several patterns. Isolated trigger pulses against a closed gate show whether a trigger starts a sweep. Triggers during holdoff, in X-Y mode and in a disarmed single mode show whether the disable path blocks them. Long trigger-free stretches in auto mode separate the free-run start from a genuine trigger start. Settings reloads in the middle of a sweep show whether holdoff preempts a running sweep. The random section mixes bursty and sparse triggers, random end-of-sweep timing, mode changes and rearm pulses. It compares every output on every cycle with a cycle model derived from the requirements, so ordering effects such as a trigger arriving in the last cycle of holdoff are covered.

// File: rtl/sweep_ctrl_pkg.sv
// Shared types for the sweep gate controller.
// Assumes a two-bit mode field whose codes are fixed by the requirements.
package sweep_ctrl_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_AUTO   = 2'b01,
        MODE_SINGLE = 2'b10,
        MODE_XY     = 2'b11
    } sweep_mode_e;

endpackage

// File: rtl/sweep_down_timer.sv
// Retriggerable down-counting timer.
// A load sets the count to LEN. The output is high while the count is nonzero,
// so it stays high for exactly LEN cycles after the most recent load.
// Assumes LEN >= 1.
module sweep_down_timer #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic active
);
    localparam int W = $clog2(LEN + 1);

    logic [W-1:0] cnt;

    // Load on request, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= W'(LEN);
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign active = (cnt != '0);

    // R4 R6 R10
    // timer_load_chk
    timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> active);

    // R4 R6
    // timer_idle_chk
    timer_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !load) |=> !active);
endmodule

// File: rtl/sweep_idle_counter.sv
// Saturating idle counter for auto-mode free run.
// It clears on request and counts up to LIMIT. The output is high once LIMIT
// cycles have passed since the last clear. Assumes LIMIT >= 1.
module sweep_idle_counter #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    // Clear on request, otherwise count up and hold at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (cnt != W'(LIMIT))
            cnt <= cnt + W'(1);
    end

    assign expired = (cnt == W'(LIMIT));

    // R7
    // idle_clear_chk
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !expired);
endmodule

// File: rtl/sweep_mode_logic.sv
// Mode decoding, single-sweep arming, sweep disable and auto-start request.
// Assumes holdoff_act comes from the holdoff timer and start is the final
// sweep-start decision made in the top.
module sweep_mode_logic
    import sweep_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  sweep_mode_e mode,
    input  logic        ss_reset,
    input  logic        start,
    input  logic        holdoff_act,
    input  logic        gate,
    input  logic        idle_expired,
    output logic        dis,
    output logic        auto_req,
    output logic        xy_mode
);
    logic armed;

    // Arm on a single-sweep reset; disarm when a single-mode sweep starts.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (ss_reset)
            armed <= 1'b1;
        else if (start && mode == MODE_SINGLE)
            armed <= 1'b0;
    end

    // Combine the blocking conditions and form the free-run request.
    always_comb begin
        xy_mode  = (mode == MODE_XY);
        dis      = holdoff_act || xy_mode || (mode == MODE_SINGLE && !armed);
        auto_req = (mode == MODE_AUTO) && idle_expired && !dis && !gate;
    end

    // R8
    // single_disarm_chk
    single_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode == MODE_SINGLE && !ss_reset) |=> !armed);
endmodule

// File: rtl/sweep_gate_ctrl.sv
// Sweep gate and holdoff controller for an oscilloscope timebase.
// It holds the sweep-gate flip-flop and generates the holdoff-start pulse,
// and instances the holdoff timer, the trigger-presence timer, the auto idle
// counter and the mode logic. Assumes trig_pulse, ss_reset and chain_load are
// synchronous to clk and eos stays high until holdoff begins.
module sweep_gate_ctrl
    import sweep_ctrl_pkg::*;
#(
    parameter int HOLD_CYC = 16,
    parameter int PRES_CYC = 40,
    parameter int AUTO_CYC = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_pulse,
    input  logic       eos,
    input  logic [1:0] mode,
    input  logic       ss_reset,
    input  logic       chain_load,
    output logic       sweep_gate,
    output logic       holdoff,
    output logic       trig_present,
    output logic       trig_det_n,
    output logic       auto_start,
    output logic       sweep_dis_n
);
    sweep_mode_e mode_e;
    logic        gate_q;
    logic        hold_act;
    logic        dis;
    logic        xy_mode;
    logic        auto_req;
    logic        idle_exp;
    logic        hold_start;
    logic        accept_trig;
    logic        start;
    logic        idle_clear;

    assign mode_e = sweep_mode_e'(mode);

    // Form the start, accept and holdoff-start decisions.
    always_comb begin
        accept_trig = trig_pulse && !dis;
        start       = !dis && (trig_pulse || auto_req);
        hold_start  = chain_load || (eos && gate_q && !hold_act);
        idle_clear  = hold_act || trig_pulse;
    end

    // Sweep-gate flip-flop: holdoff or X-Y clears it, a start sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gate_q <= 1'b0;
        else if (hold_act || xy_mode)
            gate_q <= 1'b0;
        else if (start)
            gate_q <= 1'b1;
    end

    sweep_down_timer #(.LEN(HOLD_CYC)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (hold_start),
        .active (hold_act)
    );

    sweep_down_timer #(.LEN(PRES_CYC)) u_pres (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept_trig),
        .active (trig_present)
    );

    sweep_idle_counter #(.LIMIT(AUTO_CYC)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (idle_clear),
        .expired (idle_exp)
    );

    sweep_mode_logic u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (mode_e),
        .ss_reset     (ss_reset),
        .start        (start),
        .holdoff_act  (hold_act),
        .gate         (gate_q),
        .idle_expired (idle_exp),
        .dis          (dis),
        .auto_req     (auto_req),
        .xy_mode      (xy_mode)
    );

    // Drive the outputs from internal state.
    always_comb begin
        sweep_gate  = gate_q;
        holdoff     = hold_act;
        trig_det_n  = !trig_present;
        auto_start  = auto_req;
        sweep_dis_n = !dis;
    end

    // R3
    // blocked_gate_chk
    blocked_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sweep_dis_n && !sweep_gate) |=> !sweep_gate);

    // R9
    // xy_gate_chk
    xy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |=> !sweep_gate);

    // R10
    // reload_hold_chk
    reload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_load |=> holdoff);

    // R7
    // auto_open_chk
    auto_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        auto_start |=> sweep_gate);

    // R2
    // trig_open_chk
    trig_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_pulse && sweep_dis_n) |=> sweep_gate);
endmodule

// File: tb/sweep_gate_ctrl_test.sv
module sweep_gate_ctrl_test;
    localparam int HOLD = 16;
    localparam int PRES = 40;
    localparam int AUTO = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_pulse = 1'b0, eos = 1'b0, ss_reset = 1'b0, chain_load = 1'b0;
    logic [1:0] mode = 2'b00;
    logic sweep_gate, holdoff, trig_present, trig_det_n, auto_start, sweep_dis_n;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Cycle model state, built from the requirements
    bit m_gate = 0, m_armed = 0;
    int m_hold = 0, m_pres = 0, m_idle = 0;

    sweep_gate_ctrl #(.HOLD_CYC(HOLD), .PRES_CYC(PRES), .AUTO_CYC(AUTO)) uut (
        .clk(clk), .rst_n(rst_n), .trig_pulse(trig_pulse), .eos(eos), .mode(mode),
        .ss_reset(ss_reset), .chain_load(chain_load), .sweep_gate(sweep_gate),
        .holdoff(holdoff), .trig_present(trig_present), .trig_det_n(trig_det_n),
        .auto_start(auto_start), .sweep_dis_n(sweep_dis_n)
    );

    always #4 clk = ~clk;

    function automatic bit exp_dis();
        return (m_hold != 0) || (mode == 2'b11) || (mode == 2'b10 && !m_armed);
    endfunction

    function automatic bit exp_auto();
        return (mode == 2'b01) && (m_idle == AUTO) && !exp_dis() && !m_gate;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, expv, cyc);
        end
    endtask

    // Advance the model at each clock edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_gate = 0; m_armed = 0; m_hold = 0; m_pres = 0; m_idle = 0;
        end else begin
            bit dis, hs, st, ng;
            dis = exp_dis();
            hs  = chain_load || (eos && m_gate && m_hold == 0);
            st  = !dis && (trig_pulse || exp_auto());
            ng  = (m_hold != 0 || mode == 2'b11) ? 1'b0 : (st ? 1'b1 : m_gate);
            if (ss_reset) m_armed = 1;
            else if (st && mode == 2'b10) m_armed = 0;
            m_idle = (m_hold != 0 || trig_pulse) ? 0 : ((m_idle < AUTO) ? m_idle + 1 : m_idle);
            m_pres = (trig_pulse && !dis) ? PRES : ((m_pres > 0) ? m_pres - 1 : 0);
            m_hold = hs ? HOLD : ((m_hold > 0) ? m_hold - 1 : 0);
            m_gate = ng;
        end
    end

    // Lockstep comparison of every output, away from the active edge
    always @(negedge clk) begin
        if (cyc > 0 && !done) begin
            chk(sweep_gate == m_gate, "R2 sweep_gate", sweep_gate, m_gate);
            chk(holdoff == (m_hold != 0), "R4 holdoff", holdoff, m_hold != 0);
            chk(trig_present == (m_pres != 0), "R6 trig_present", trig_present, m_pres != 0);
            chk(trig_det_n == (m_pres == 0), "R6 trig_det_n", trig_det_n, m_pres == 0);
            chk(sweep_dis_n == !exp_dis(), "R5 sweep_dis_n", sweep_dis_n, !exp_dis());
            chk(auto_start == exp_auto(), "R7 auto_start", auto_start, exp_auto());
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic pulse_trig();
        trig_pulse = 1; tick(); trig_pulse = 0;
    endtask

    task automatic wait_hold_end();
        for (int i = 0; i < 4 * HOLD && holdoff; i++) tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 190000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
            finish_run();
        end
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        tick(); tick();
        // R1 during reset
        chk(!sweep_gate && !holdoff && !trig_present && trig_det_n && !auto_start,
            "R1 reset", {sweep_gate, holdoff, trig_present, trig_det_n, auto_start}, 5'b00010);
        rst_n = 1; tick();
        // R1 first cycle after reset
        chk(!sweep_gate && !holdoff && trig_det_n && !auto_start, "R1 post", sweep_gate, 0);

        // R2 normal mode trigger opens the gate
        pulse_trig();
        chk(sweep_gate == 1, "R2 trig opens gate", sweep_gate, 1);
        chk(trig_present == 1, "R6 present after trig", trig_present, 1);

        // R4 holdoff length and gate clearing
        eos = 1; tick(); eos = 0;
        n = 0;
        while (holdoff && n < 4 * HOLD) begin
            n++;
            if (n == 2) chk(sweep_gate == 0, "R4 gate cleared", sweep_gate, 0);
            if (n == 3) begin
                chk(sweep_dis_n == 0, "R5 dis in holdoff", sweep_dis_n, 0);
                trig_pulse = 1;
            end
            tick();
            trig_pulse = 0;
            if (n == 3) chk(sweep_gate == 0, "R3 trig ignored in holdoff", sweep_gate, 0);
        end
        chk(n == HOLD, "R4 holdoff length", n, HOLD);

        // R6 presence length after the last accepted trigger
        for (int i = 0; i < 2 * PRES && trig_present; i++) tick();
        pulse_trig();
        n = 0;
        while (trig_present && n < 4 * PRES) begin n++; tick(); end
        chk(n == PRES, "R6 presence length", n, PRES);

        // R10 reload forces holdoff
        chain_load = 1; tick(); chain_load = 0;
        chk(holdoff == 1, "R10 reload holdoff", holdoff, 1);
        tick();
        chk(sweep_gate == 0, "R10 sweep ended", sweep_gate, 0);
        wait_hold_end();

        // R9 X-Y mode
        mode = 2'b11; tick();
        chk(sweep_dis_n == 0, "R5 dis in xy", sweep_dis_n, 0);
        pulse_trig();
        chk(sweep_gate == 0 && trig_present == 0, "R9 xy ignores trig", sweep_gate, 0);

        // R7 auto free run, counted from the end of holdoff
        mode = 2'b01;
        chain_load = 1; tick(); chain_load = 0;
        wait_hold_end();
        n = 0;
        while (!auto_start && n < 4 * AUTO) begin n++; tick(); end
        chk(n == AUTO, "R7 auto delay", n, AUTO);
        tick();
        chk(sweep_gate == 1, "R7 auto opens gate", sweep_gate, 1);

        // R8 single sweep per rearm
        mode = 2'b10;
        chain_load = 1; tick(); chain_load = 0;
        wait_hold_end();
        chk(sweep_dis_n == 0, "R8 disarmed", sweep_dis_n, 0);
        pulse_trig();
        chk(sweep_gate == 0, "R8 no sweep unarmed", sweep_gate, 0);
        ss_reset = 1; tick(); ss_reset = 0;
        chk(sweep_dis_n == 1, "R8 armed", sweep_dis_n, 1);
        pulse_trig();
        chk(sweep_gate == 1, "R8 one sweep", sweep_gate, 1);
        eos = 1; tick(); eos = 0;
        wait_hold_end();
        chk(sweep_dis_n == 0, "R8 disarmed after sweep", sweep_dis_n, 0);
        pulse_trig();
        chk(sweep_gate == 0, "R8 second trig blocked", sweep_gate, 0);

        // Random phase, compared every cycle by the lockstep checker
        mode = 2'b00;
        for (int i = 0; i < 30000; i++) begin
            int quiet;
            quiet = ((i / 500) % 3 == 2);
            trig_pulse = !quiet && ($urandom % 9 == 0);
            eos        = m_gate && ($urandom % 5 == 0);
            chain_load = ($urandom % 300 == 0);
            ss_reset   = ($urandom % 120 == 0);
            if ($urandom % 400 == 0) mode = 2'($urandom % 4);
            tick();
        end
        trig_pulse = 0; eos = 0; chain_load = 0; ss_reset = 0;
        tick();
        finish_run();
    end
endmodule